// File: doc/BRIEF.md
# Pseudo-Random TLB Replacement Index Generator

This block picks the entry that a translation buffer should overwrite on a random refill. The lower part of the buffer can be pinned by software through a wired count, and pinned entries are never chosen. On a request strobe the block advances a 32-bit linear congruential generator. It takes the upper half of the state modulo the number of unpinned entries, adds the wired count, and returns the result with a one-cycle valid pulse.

The block never hands out the same index on two successive returns. A candidate that matches the last returned index is thrown away and the generator steps again, so latency varies from request to request. When exactly one entry is left unpinned, the answer is fixed and comes back on the next cycle without touching the generator. Buffer storage and write logic sit outside this block.

Top module: `rnd_tlb_index_gen`

## Requirements
- R1: After reset the generator state is 1, the last-returned index is 0, `idx_valid` is low and `busy` is low.
- R2: Every generator step replaces the 32-bit state S with (1103515245*S + 12345) mod 2^32. The state changes only when a candidate is drawn.
- R3: With M = ENTRIES - wired (M at least 2), a candidate is (bits 31..16 of the freshly stepped state) mod M plus wired. Every returned index therefore lies in [wired, ENTRIES-1].
- R4: A request with wired >= ENTRIES-1 returns ENTRIES-1 with `idx_valid` high on the cycle after the request. The generator does not step and the last-returned index is left unchanged.
- R5: A candidate equal to the last-returned index is rejected and a new step is drawn. This repeats until a different value appears.
- R6: Each index returned through the drawing path (not the R4 shortcut) becomes the last-returned index for the next comparison.
- R7: A request raised while `busy` is high is ignored. It yields no extra result and no extra generator step.
- R8: The wired count is sampled when a request is accepted. Changes to `wired` during a generation have no effect on that result.
- R9: `idx_valid` is a single-cycle pulse per accepted request and is never high together with `busy`.
- R10: When M is a power of two, the reduction takes a single cycle by masking. Its result equals the modulo of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe for a new replacement index |
| wired | input | CNT_W | Count of pinned low entries |
| idx_valid | output | 1 | One-cycle pulse: `idx` holds a new result |
| idx | output | IDX_W | Replacement index |
| busy | output | 1 | A generation is in progress |

## Verification
The bench runs a reference generator and repeats wired counts that leave two free entries. This forces rejections, so a design that skipped the repeat check, or compared against the wrong stored index, would return a duplicate or fall out of step with the reference. Wired counts at and above ENTRIES-1 exercise the shortcut. A design that stepped the generator there, or stored the fixed answer as the last index, would diverge on every later request. A request and a wired change raised during a generation check that neither extra pulses nor a changed range appear. Power-of-two and odd free counts exercise both reducer paths against the same arithmetic.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   localparam logic [31:0] LCG_MUL   = 32'd1103515245;
   localparam logic [31:0] LCG_INC   = 32'd12345;
   localparam logic [31:0] SEED_INIT = 32'd1;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_WAIT  = 2'd2
   } rtg_state_e;

   function automatic logic [31:0] lcg_next(input logic [31:0] s);
      return s * LCG_MUL + LCG_INC;
   endfunction

endpackage

// File: rtl/rtg_lcg.sv
module rtg_lcg
   import rtg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        step,
   output logic [31:0] seed
);

   logic [31:0] seed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seed_q <= SEED_INIT;
      else if (step) seed_q <= lcg_next(seed_q);
   end

   assign seed = seed_q;

   // odd multiplier and odd increment: the low bit flips on every step
   assert_step_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (seed[0] != $past(seed[0])));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(seed));

endmodule

// File: rtl/rtg_reduce.sv
module rtg_reduce #(
   parameter int NUM_W   = 16,
   parameter int MOD_W   = 5,
   parameter bit SEQ_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [MOD_W-1:0] modu,
   output logic             done,
   output logic [MOD_W-1:0] res
);

   localparam int CNT_W = $clog2(NUM_W + 1);

   logic             done_q;
   logic [MOD_W-1:0] res_q;

   if (MOD_W >= NUM_W) begin : g_bad_width
      $error("rtg_reduce: modulus wider than dividend");
   end

   if (SEQ_DIV) begin : g_seq
      logic [NUM_W-1:0] num_q;
      logic [MOD_W-1:0] modu_q;
      logic [MOD_W-1:0] rem_q;
      logic [CNT_W-1:0] cnt_q;
      logic             run_q;
      logic [MOD_W:0]   trial;
      logic [MOD_W-1:0] rem_d;
      logic [MOD_W-1:0] mask_res;

      assign trial    = {rem_q, num_q[NUM_W-1]};
      assign rem_d    = (trial >= {1'b0, modu_q}) ? MOD_W'(trial - {1'b0, modu_q})
                                                  : trial[MOD_W-1:0];
      assign mask_res = num[MOD_W-1:0] & (modu - MOD_W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            num_q  <= '0;
            modu_q <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
         end else if (start) begin
            if ($onehot(modu)) begin
               res_q  <= mask_res;
               done_q <= 1'b1;
               run_q  <= 1'b0;
            end else begin
               num_q  <= num;
               modu_q <= modu;
               rem_q  <= '0;
               cnt_q  <= CNT_W'(NUM_W);
               run_q  <= 1'b1;
               done_q <= 1'b0;
            end
         end else if (run_q) begin
            rem_q <= rem_d;
            num_q <= num_q << 1;
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               res_q  <= rem_d;
            end else begin
               done_q <= 1'b0;
            end
         end else begin
            done_q <= 1'b0;
         end
      end
   end else begin : g_comb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
         end else begin
            done_q <= start;
            if (start) res_q <= MOD_W'(num % NUM_W'(modu));
         end
      end
   end

   assign done = done_q;
   assign res  = res_q;

   assert_rem_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res < modu));

endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
   import rtg_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] wired,
   input  logic             red_done,
   input  logic [CNT_W-1:0] red_res,
   output logic             lcg_step,
   output logic             red_start,
   output logic [CNT_W-1:0] free_cnt,
   output logic             idx_valid,
   output logic [IDX_W-1:0] idx,
   output logic             busy
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   rtg_state_e       state_q, state_d;
   logic [CNT_W-1:0] wired_q;
   logic [CNT_W-1:0] n_q;
   logic [IDX_W-1:0] prev_q;
   logic [IDX_W-1:0] idx_q;
   logic             valid_q;
   logic             single;
   logic             accept;
   logic [CNT_W:0]   cand_w;
   logic [IDX_W-1:0] cand;

   assign single = (int'(wired) >= ENTRIES - 1);
   assign cand_w = {1'b0, red_res} + {1'b0, wired_q};
   assign cand   = cand_w[IDX_W-1:0];

   always_comb begin
      state_d   = state_q;
      lcg_step  = 1'b0;
      red_start = 1'b0;
      accept    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req && !single) begin
               lcg_step = 1'b1;
               state_d  = ST_START;
            end
         end
         ST_START: begin
            red_start = 1'b1;
            state_d   = ST_WAIT;
         end
         ST_WAIT: begin
            if (red_done) begin
               if (cand == prev_q) begin
                  lcg_step = 1'b1;
                  state_d  = ST_START;
               end else begin
                  accept  = 1'b1;
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wired_q <= '0;
         n_q     <= CNT_W'(ENTRIES);
         prev_q  <= '0;
         idx_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= 1'b0;
         if (state_q == ST_IDLE && req) begin
            wired_q <= wired;
            if (single) begin
               valid_q <= 1'b1;
               idx_q   <= LAST_IDX;
            end else begin
               n_q <= CNT_W'(ENTRIES) - wired;
            end
         end
         if (accept) begin
            valid_q <= 1'b1;
            idx_q   <= cand;
            prev_q  <= cand;
         end
      end
   end

   assign free_cnt  = n_q;
   assign idx_valid = valid_q;
   assign idx       = idx_q;
   assign busy      = (state_q != ST_IDLE);

   // checker state derived from the ports only
   logic             chk_short;
   logic [IDX_W-1:0] chk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_short <= 1'b0;
         chk_prev  <= '0;
      end else begin
         chk_short <= req && !busy && single;
         if (idx_valid && !chk_short) chk_prev <= idx;
      end
   end

   assert_shortcut_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && single) |=> (idx_valid && idx == LAST_IDX));

   assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && !chk_short) |-> (idx != chk_prev));

   assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && !chk_short) |-> ({1'b0, idx} >= {1'b0, wired_q} &&
                                     int'(idx) < ENTRIES));

   assert_wired_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(wired_q));

   assert_valid_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> !busy);

endmodule

// File: rtl/rnd_tlb_index_gen.sv
module rnd_tlb_index_gen #(
   parameter int ENTRIES = 16,
   parameter bit SEQ_DIV = 1'b1,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] wired,
   output logic             idx_valid,
   output logic [IDX_W-1:0] idx,
   output logic             busy
);

   localparam int HALF_W = 16;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("rnd_tlb_index_gen: ENTRIES must lie in 2..64");
   end

   logic [31:0]      seed;
   logic             lcg_step;
   logic             red_start;
   logic             red_done;
   logic [CNT_W-1:0] red_res;
   logic [CNT_W-1:0] free_cnt;

   rtg_lcg u_lcg (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (lcg_step),
      .seed  (seed)
   );

   rtg_reduce #(
      .NUM_W   (HALF_W),
      .MOD_W   (CNT_W),
      .SEQ_DIV (SEQ_DIV)
   ) u_reduce (
      .clk   (clk),
      .rst_n (rst_n),
      .start (red_start),
      .num   (seed[31:16]),
      .modu  (free_cnt),
      .done  (red_done),
      .res   (red_res)
   );

   rtg_ctrl #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W),
      .CNT_W   (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .wired     (wired),
      .red_done  (red_done),
      .red_res   (red_res),
      .lcg_step  (lcg_step),
      .red_start (red_start),
      .free_cnt  (free_cnt),
      .idx_valid (idx_valid),
      .idx       (idx),
      .busy      (busy)
   );

endmodule

// File: tb/sim_rnd_tlb_index_gen.sv
module sim_rnd_tlb_index_gen;

   localparam int CLK_PERIOD = 10;
   localparam int ENTRIES    = 16;
   localparam int IDX_W      = 4;
   localparam int CNT_W      = 5;
   localparam int NV         = 16;
   localparam int WAIT_MAX   = 400;
   localparam int WDOG_MAX   = 150000;
   // wired counts: mix of mask path (0,8,12,14), divide path, shortcut (15,20)
   localparam int VEC_WIRED [NV] = '{0, 3, 12, 14, 14, 14, 7, 15, 2, 14, 1, 9, 20, 13, 13, 8};

   logic             clk;
   logic             rst_n;
   logic             req;
   logic [CNT_W-1:0] wired;
   logic             idx_valid;
   logic [IDX_W-1:0] idx;
   logic             busy;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   logic [31:0] m_seed;
   int          m_prev;
   int          m_rejects;
   int          last_drawn;

   rnd_tlb_index_gen #(.ENTRIES(ENTRIES)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .wired     (wired),
      .idx_valid (idx_valid),
      .idx       (idx),
      .busy      (busy)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WDOG_MAX) begin
         failures = failures + 1;
         $display("FAIL watchdog expired at cycle %0d", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_seed     = 32'd1;
      m_prev     = 0;
      last_drawn = -1;
   endtask

   task automatic model_draw(input int w, output int e, output bit short);
      int n;
      int c;
      if (w >= ENTRIES - 1) begin
         e     = ENTRIES - 1;
         short = 1'b1;
      end else begin
         short = 1'b0;
         n = ENTRIES - w;
         do begin
            m_seed = m_seed * 32'd1103515245 + 32'd12345;
            c = (int'(m_seed[31:16]) % n) + w;
            if (c == m_prev) m_rejects = m_rejects + 1;
         end while (c == m_prev);
         m_prev = c;
         e = c;
      end
   endtask

   // drive a request; returns index (-1 on timeout) and cycles to valid
   task automatic do_req(input int w, output int got, output int lat);
      @(negedge clk);
      wired = CNT_W'(w);
      req   = 1'b1;
      @(negedge clk);
      req = 1'b0;
      lat = 1;
      while (!idx_valid && lat < WAIT_MAX) begin
         @(negedge clk);
         lat = lat + 1;
      end
      got = idx_valid ? int'(idx) : -1;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      req   = 1'b0;
      wired = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      int got;
      int lat;
      int exp;
      bit short;
      int vcount;

      m_rejects = 0;
      apply_reset();
      @(negedge clk);
      check(idx_valid == 1'b0, "R1 valid low after reset", int'(idx_valid), 0);
      check(busy == 1'b0, "R1 busy low after reset", int'(busy), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         int w;
         w = VEC_WIRED[i];
         model_draw(w, exp, short);
         do_req(w, got, lat);
         check(got == exp, $sformatf("R2 R3 R5 R6 R10 vector %0d wired=%0d", i, w), got, exp);
         if (short) begin
            check(lat == 1, "R4 shortcut latency", lat, 1);
         end else begin
            check(got >= w && got < ENTRIES, "R3 index in range", got, w);
            check(got != last_drawn, "R5 no back-to-back repeat", got, last_drawn);
            last_drawn = got;
         end
         check(busy == 1'b0, "R9 busy low with valid", int'(busy), 0);
         @(negedge clk);
         check(idx_valid == 1'b0, "R9 valid is a single pulse", int'(idx_valid), 0);
      end
      check(m_rejects > 0, "R5 rejections occurred", m_rejects, 1);

      // R7 / R8: extra request and wired change while busy
      model_draw(5, exp, short);
      @(negedge clk);
      wired = CNT_W'(5);
      req   = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check(busy == 1'b1, "R7 busy during generation", int'(busy), 1);
      @(negedge clk);
      req   = 1'b1;
      wired = CNT_W'(0);
      @(negedge clk);
      req = 1'b0;
      vcount = 0;
      got    = -1;
      for (int k = 0; k < 120; k++) begin
         if (idx_valid) begin
            vcount = vcount + 1;
            got    = int'(idx);
         end
         @(negedge clk);
      end
      check(vcount == 1, "R7 one result for overlapped requests", vcount, 1);
      check(got == exp, "R8 wired sampled at request", got, exp);
      // the ignored request must not have stepped the generator
      model_draw(0, exp, short);
      do_req(0, got, lat);
      check(got == exp, "R7 no extra generator step", got, exp);

      // R4: shortcut leaves generator and last index untouched
      model_draw(15, exp, short);
      do_req(15, got, lat);
      check(got == 15 && lat == 1, "R4 shortcut value", got, 15);
      model_draw(14, exp, short);
      do_req(14, got, lat);
      check(got == exp, "R4 R6 draw after shortcut", got, exp);

      // R1: second reset restarts the sequence
      apply_reset();
      model_draw(3, exp, short);
      do_req(3, got, lat);
      check(got == exp, "R1 sequence restarts from seed 1", got, exp);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule